// File: doc/BRIEF.md
# Exception Entry Sequencer

This block steps a processor core into an exception. A rising edge on the reset input starts a reset entry. In that entry the level of the non-maskable interrupt input at the first clock after reset is released selects one of two reset flavours. The block reads a start PC and a start stack pointer from fixed low addresses, clears the vector base and raises the interrupt mask to its highest value.

Every other exception is taken from the idle state. These are an address error, an external interrupt, a trap instruction, an undefined instruction, and an illegal instruction in a delay slot. For these the block saves the status word and the return PC on the stack below the current stack pointer. It then reads the handler address from the vector table at the vector base plus four times the vector number. Only an interrupt changes the mask: it is written with the interrupt's level.

All memory traffic goes over one 32-bit request/acknowledge port. Results reach the register file as one-cycle write strobes with values. While a sequence runs, `busy` holds the pipeline.

States and transitions:
- HOLD: the reset input is low. HOLD goes to RST_PC at the first clock after the reset input rises.
- RST_PC: reads the start PC. On acknowledge it goes to RST_SP.
- RST_SP: reads the start SP. On acknowledge it commits the reset values and goes to IDLE.
- IDLE: waits for an accepted cause. When one is accepted it goes to PUSH_SR.
- PUSH_SR: writes the status word. On acknowledge it goes to PUSH_PC.
- PUSH_PC: writes the return PC. On acknowledge it goes to VEC.
- VEC: reads the handler address. On acknowledge it commits the entry values and goes to IDLE.
- A low level on the reset input moves any state to HOLD at once.

Top module: `exc_entry_seq`

## Requirements
- R1: At the first clock after `reset_pin` rises, `nmi_lvl` = 1 selects power-on reset and `nmi_lvl` = 0 selects manual reset. Power-on reset reads the PC from 0x0 and then the SP from 0x4. Manual reset reads the PC from 0x8 and then the SP from 0xC.
- R2: A reset entry ends with one cycle in which `pc_we`, `sp_we`, `vbr_we` and `mask_we` are all high. In that cycle `pc_val` is the first word read, `sp_val` is the second word read, `vbr_val` is 0 and `mask_val` is 4'b1111.
- R3: While `reset_pin` is low, `busy` is high and `mem_req` and all write strobes are low. Taking `reset_pin` low aborts any sequence in progress.
- R4: Any other entry makes exactly two writes, in this order: `sr_in` to `sp_in`-4, then `pc_in` to `sp_in`-8. The values used are those sampled in the accept cycle.
- R5: Any other entry then reads `vbr_in` + 4×vector. It commits `pc_val` = the word read and `sp_val` = `sp_in`-8, and leaves `vbr_we` low.
- R6: The vector number depends on the cause. A trap uses `trap_imm`, an interrupt uses `irq_vec`, an address error uses 9, a general illegal instruction uses 4, and an illegal delay-slot instruction uses 6.
- R7: An interrupt entry strobes `mask_we` with `mask_val` = `irq_lvl`. Every other non-reset entry leaves `mask_we` low.
- R8: An interrupt or an address error is accepted only in a cycle with `insn_done` high. Instruction causes are accepted whatever the level of `insn_done`.
- R9: When several causes are present in the same cycle, the priority is: address error, then interrupt, then illegal slot, then general illegal, then trap.
- R10: Each transfer holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`, and the sequence advances only on `mem_ack`.
- R11: `busy` is high from the cycle after acceptance until the commit cycle, and it is low in the commit cycle.
- R12: Every write strobe is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset_pin | input | 1 | Processor reset, active low. A rising edge starts the reset entry |
| nmi_lvl | input | 1 | NMI level. Selects the reset flavour |
| insn_done | input | 1 | Current instruction has completed |
| addr_err | input | 1 | Address error pending |
| irq_req | input | 1 | Interrupt request |
| irq_lvl | input | 4 | Interrupt priority level |
| irq_vec | input | 8 | Interrupt vector number |
| trap_dec | input | 1 | Trap instruction decoded |
| trap_imm | input | 8 | Trap vector number from the immediate field |
| illeg_dec | input | 1 | Undefined code outside a delay slot |
| slot_illeg_dec | input | 1 | Undefined or PC-writing code in a delay slot |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Return PC |
| sp_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Current vector base |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| busy | output | 1 | Pipeline stall |
| pc_we | output | 1 | PC write strobe |
| pc_val | output | 32 | New PC |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_val | output | 32 | New stack pointer |
| vbr_we | output | 1 | Vector base write strobe |
| vbr_val | output | 32 | New vector base |
| mask_we | output | 1 | Interrupt mask write strobe |
| mask_val | output | 4 | New interrupt mask |

## Verification
A wrong state or a lost latch shows up as a wrong address or wrong data on the memory port within one transfer of the error. A wrong push order, a wrong vector offset or a wrong reset flavour appears as soon as the first affected request is issued. A wrong cause or a wrong committed value appears in the single commit cycle as a wrong `pc_val`, a wrong `sp_val` or a wrong mask strobe. A sequencer that fails to advance leaves `busy` high and never strobes `pc_we`.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [2:0] {
        S_HOLD,
        S_RST_PC,
        S_RST_SP,
        S_IDLE,
        S_PUSH_SR,
        S_PUSH_PC,
        S_VEC
    } seq_state_e;

    typedef enum logic [2:0] {
        C_NONE,
        C_ADDR,
        C_IRQ,
        C_SLOT,
        C_ILLEG,
        C_TRAP
    } cause_e;

endpackage

// File: rtl/exc_pick.sv
module exc_pick
    import exc_seq_pkg::*;
#(
    parameter int VW        = 8,
    parameter int LW        = 4,
    parameter int VEC_ADDR  = 9,
    parameter int VEC_ILLEG = 4,
    parameter int VEC_SLOT  = 6
) (
    input  logic          insn_done,
    input  logic          addr_err,
    input  logic          irq_req,
    input  logic [LW-1:0] irq_lvl,
    input  logic [VW-1:0] irq_vec,
    input  logic          trap_dec,
    input  logic [VW-1:0] trap_imm,
    input  logic          illeg_dec,
    input  logic          slot_illeg_dec,
    output cause_e        cause,
    output logic [VW-1:0] vec,
    output logic [LW-1:0] lvl
);

    // Fixed priority: boundary-gated causes first, then decode causes.
    always_comb begin
        cause = C_NONE;
        vec   = '0;
        lvl   = irq_lvl;
        if (insn_done && addr_err) begin
            cause = C_ADDR;
            vec   = VW'(VEC_ADDR);
        end else if (insn_done && irq_req) begin
            cause = C_IRQ;
            vec   = irq_vec;
        end else if (slot_illeg_dec) begin
            cause = C_SLOT;
            vec   = VW'(VEC_SLOT);
        end else if (illeg_dec) begin
            cause = C_ILLEG;
            vec   = VW'(VEC_ILLEG);
        end else if (trap_dec) begin
            cause = C_TRAP;
            vec   = trap_imm;
        end
    end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int VW = 8,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          reset_pin,
    input  logic          nmi_lvl,
    input  logic          insn_done,
    input  cause_e        cause,
    input  logic [VW-1:0] vec,
    input  logic [LW-1:0] lvl,
    input  logic [DW-1:0] sr_in,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] vbr_in,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          fin_rst,
    output logic          fin_exc,
    output logic [DW-1:0] pc_buf,
    output logic [DW-1:0] sp_new,
    output logic [LW-1:0] lvl_out,
    output logic          irq_out
);

    localparam int STEP = DW / 8;
    localparam int WB   = $clog2(STEP);
    localparam logic [DW-1:0] POR_PC = '0;
    localparam logic [DW-1:0] POR_SP = DW'(STEP);
    localparam logic [DW-1:0] MAN_PC = DW'(2 * STEP);
    localparam logic [DW-1:0] MAN_SP = DW'(3 * STEP);

    seq_state_e    state_q, state_n;
    cause_e        cause_q;
    logic          por_q;
    logic [VW-1:0] vec_q;
    logic [LW-1:0] lvl_q;
    logic [DW-1:0] sr_q, pc_q, sp_q, vbr_q, pcbuf_q;
    logic [DW-1:0] vec_off;

    assign vec_off = {{(DW-VW-WB){1'b0}}, vec_q, {WB{1'b0}}};

    // State register
    always_ff @(posedge clk or negedge reset_pin) begin
        if (!reset_pin) state_q <= S_HOLD;
        else            state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_HOLD:    state_n = S_RST_PC;
            S_RST_PC:  if (mem_ack) state_n = S_RST_SP;
            S_RST_SP:  if (mem_ack) state_n = S_IDLE;
            S_IDLE:    if (cause != C_NONE) state_n = S_PUSH_SR;
            S_PUSH_SR: if (mem_ack) state_n = S_PUSH_PC;
            S_PUSH_PC: if (mem_ack) state_n = S_VEC;
            S_VEC:     if (mem_ack) state_n = S_IDLE;
            default:   state_n = S_HOLD;
        endcase
    end

    // Context captured at reset release and at acceptance
    always_ff @(posedge clk or negedge reset_pin) begin
        if (!reset_pin) begin
            por_q   <= 1'b0;
            cause_q <= C_NONE;
            vec_q   <= '0;
            lvl_q   <= '0;
            sr_q    <= '0;
            pc_q    <= '0;
            sp_q    <= '0;
            vbr_q   <= '0;
            pcbuf_q <= '0;
        end else begin
            if (state_q == S_HOLD) por_q <= nmi_lvl;
            if (state_q == S_RST_PC && mem_ack) pcbuf_q <= mem_rdata;
            if (state_q == S_IDLE && cause != C_NONE) begin
                cause_q <= cause;
                vec_q   <= vec;
                lvl_q   <= lvl;
                sr_q    <= sr_in;
                pc_q    <= pc_in;
                sp_q    <= sp_in;
                vbr_q   <= vbr_in;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        fin_rst   = 1'b0;
        fin_exc   = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            S_HOLD: ;
            S_RST_PC: begin
                mem_req  = 1'b1;
                mem_addr = por_q ? POR_PC : MAN_PC;
            end
            S_RST_SP: begin
                mem_req  = 1'b1;
                mem_addr = por_q ? POR_SP : MAN_SP;
                fin_rst  = mem_ack;
            end
            S_IDLE: busy = 1'b0;
            S_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - DW'(STEP);
                mem_wdata = sr_q;
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - DW'(2 * STEP);
                mem_wdata = pc_q;
            end
            S_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vbr_q + vec_off;
                fin_exc  = mem_ack;
            end
            default: ;
        endcase
    end

    assign pc_buf  = pcbuf_q;
    assign sp_new  = sp_q - DW'(2 * STEP);
    assign lvl_out = lvl_q;
    assign irq_out = (cause_q == C_IRQ);

    // R10: a request is held unchanged until it is acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!reset_pin)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R8: an interrupt is accepted only at an instruction boundary
    p_irq_boundary_r8: assert property (@(posedge clk) disable iff (!reset_pin)
        (state_q == S_IDLE && cause == C_IRQ) |-> insn_done);

    // R4: the PC push follows the SR push one word further down
    p_push_order_r4: assert property (@(posedge clk) disable iff (!reset_pin)
        (state_q == S_PUSH_SR && mem_ack) |=> mem_we && (mem_addr == $past(mem_addr) - DW'(STEP)));

endmodule

// File: rtl/exc_commit.sv
module exc_commit #(
    parameter int DW = 32,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          reset_pin,
    input  logic          fin_rst,
    input  logic          fin_exc,
    input  logic          irq_q,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] pc_buf,
    input  logic [DW-1:0] sp_new,
    input  logic [LW-1:0] lvl_q,
    output logic          pc_we,
    output logic [DW-1:0] pc_val,
    output logic          sp_we,
    output logic [DW-1:0] sp_val,
    output logic          vbr_we,
    output logic [DW-1:0] vbr_val,
    output logic          mask_we,
    output logic [LW-1:0] mask_val
);

    always_ff @(posedge clk or negedge reset_pin) begin
        if (!reset_pin) begin
            pc_we    <= 1'b0;
            sp_we    <= 1'b0;
            vbr_we   <= 1'b0;
            mask_we  <= 1'b0;
            pc_val   <= '0;
            sp_val   <= '0;
            vbr_val  <= '0;
            mask_val <= '0;
        end else begin
            pc_we   <= fin_rst | fin_exc;
            sp_we   <= fin_rst | fin_exc;
            vbr_we  <= fin_rst;
            mask_we <= fin_rst | (fin_exc & irq_q);
            if (fin_rst) begin
                pc_val   <= pc_buf;
                sp_val   <= mem_rdata;
                vbr_val  <= '0;
                mask_val <= '1;
            end else if (fin_exc) begin
                pc_val <= mem_rdata;
                sp_val <= sp_new;
                if (irq_q) mask_val <= lvl_q;
            end
        end
    end

    // R12: strobes last one cycle
    p_strobe_pulse_r12: assert property (@(posedge clk) disable iff (!reset_pin)
        pc_we |=> !pc_we && !sp_we && !vbr_we && !mask_we);

    // R2: a reset commit writes every target with the reset values
    p_reset_commit_r2: assert property (@(posedge clk) disable iff (!reset_pin)
        vbr_we |-> pc_we && sp_we && mask_we && (vbr_val == '0) && (mask_val == '1));

    // R7: the mask moves only together with a PC commit
    p_mask_with_pc_r7: assert property (@(posedge clk) disable iff (!reset_pin)
        mask_we |-> pc_we);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int DW        = 32,
    parameter int VW        = 8,
    parameter int LW        = 4,
    parameter int VEC_ADDR  = 9,
    parameter int VEC_ILLEG = 4,
    parameter int VEC_SLOT  = 6
) (
    input  logic          clk,
    input  logic          reset_pin,
    input  logic          nmi_lvl,
    input  logic          insn_done,
    input  logic          addr_err,
    input  logic          irq_req,
    input  logic [LW-1:0] irq_lvl,
    input  logic [VW-1:0] irq_vec,
    input  logic          trap_dec,
    input  logic [VW-1:0] trap_imm,
    input  logic          illeg_dec,
    input  logic          slot_illeg_dec,
    input  logic [DW-1:0] sr_in,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] vbr_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          pc_we,
    output logic [DW-1:0] pc_val,
    output logic          sp_we,
    output logic [DW-1:0] sp_val,
    output logic          vbr_we,
    output logic [DW-1:0] vbr_val,
    output logic          mask_we,
    output logic [LW-1:0] mask_val
);

    cause_e        cause;
    logic [VW-1:0] vec;
    logic [LW-1:0] lvl;
    logic          fin_rst, fin_exc, irq_q;
    logic [DW-1:0] pc_buf, sp_new;
    logic [LW-1:0] lvl_q;

    exc_pick #(
        .VW(VW), .LW(LW), .VEC_ADDR(VEC_ADDR), .VEC_ILLEG(VEC_ILLEG), .VEC_SLOT(VEC_SLOT)
    ) u_pick (
        .insn_done(insn_done), .addr_err(addr_err), .irq_req(irq_req),
        .irq_lvl(irq_lvl), .irq_vec(irq_vec), .trap_dec(trap_dec),
        .trap_imm(trap_imm), .illeg_dec(illeg_dec), .slot_illeg_dec(slot_illeg_dec),
        .cause(cause), .vec(vec), .lvl(lvl)
    );

    exc_seq #(.DW(DW), .VW(VW), .LW(LW)) u_seq (
        .clk(clk), .reset_pin(reset_pin), .nmi_lvl(nmi_lvl), .insn_done(insn_done),
        .cause(cause), .vec(vec), .lvl(lvl),
        .sr_in(sr_in), .pc_in(pc_in), .sp_in(sp_in), .vbr_in(vbr_in),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .fin_rst(fin_rst), .fin_exc(fin_exc),
        .pc_buf(pc_buf), .sp_new(sp_new), .lvl_out(lvl_q), .irq_out(irq_q)
    );

    exc_commit #(.DW(DW), .LW(LW)) u_commit (
        .clk(clk), .reset_pin(reset_pin), .fin_rst(fin_rst), .fin_exc(fin_exc),
        .irq_q(irq_q), .mem_rdata(mem_rdata), .pc_buf(pc_buf), .sp_new(sp_new),
        .lvl_q(lvl_q),
        .pc_we(pc_we), .pc_val(pc_val), .sp_we(sp_we), .sp_val(sp_val),
        .vbr_we(vbr_we), .vbr_val(vbr_val), .mask_we(mask_we), .mask_val(mask_val)
    );

    // R11: the pipeline is released in the commit cycle
    p_busy_commit_r11: assert property (@(posedge clk) disable iff (!reset_pin)
        pc_we |-> !busy);

    // R11: busy falls only together with a commit
    p_busy_fall_r11: assert property (@(posedge clk) disable iff (!reset_pin)
        $fell(busy) |-> pc_we);

endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        reset_pin, nmi_lvl, insn_done, addr_err, irq_req;
    logic [3:0]  irq_lvl;
    logic [7:0]  irq_vec, trap_imm;
    logic        trap_dec, illeg_dec, slot_illeg_dec;
    logic [31:0] sr_in, pc_in, sp_in, vbr_in;
    logic        mem_req, mem_we, mem_ack, busy;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        pc_we, sp_we, vbr_we, mask_we;
    logic [31:0] pc_val, sp_val, vbr_val;
    logic [3:0]  mask_val;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    int wcnt   = 0;
    bit done   = 0;

    logic [31:0] w_addr [256];
    logic [31:0] w_data [256];
    logic [31:0] r_addr [256];
    logic [7:0]  n_wr = 0;
    logic [7:0]  n_rd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq uut (
        .clk(clk), .reset_pin(reset_pin), .nmi_lvl(nmi_lvl), .insn_done(insn_done),
        .addr_err(addr_err), .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec),
        .trap_dec(trap_dec), .trap_imm(trap_imm), .illeg_dec(illeg_dec),
        .slot_illeg_dec(slot_illeg_dec), .sr_in(sr_in), .pc_in(pc_in), .sp_in(sp_in),
        .vbr_in(vbr_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy),
        .pc_we(pc_we), .pc_val(pc_val), .sp_we(sp_we), .sp_val(sp_val),
        .vbr_we(vbr_we), .vbr_val(vbr_val), .mask_we(mask_we), .mask_val(mask_val)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a << 3) ^ 32'h9E37_79B9;
    endfunction

    // Memory model: acknowledges after lat wait cycles, logs each transfer
    initial begin mem_ack = 1'b0; mem_rdata = '0; end
    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= memf(mem_addr);
                wcnt      <= 0;
                if (mem_we) begin
                    w_addr[n_wr] <= mem_addr;
                    w_data[n_wr] <= mem_wdata;
                    n_wr         <= n_wr + 8'd1;
                end else begin
                    r_addr[n_rd] <= mem_addr;
                    n_rd         <= n_rd + 8'd1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            wcnt <= 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_req();
        addr_err = 0; irq_req = 0; trap_dec = 0; illeg_dec = 0; slot_illeg_dec = 0;
    endtask

    task automatic wait_commit(output bit seen, output bit busy_ok);
        seen = 0;
        busy_ok = 1;
        for (int i = 0; i < 200; i++) begin
            if (pc_we) begin seen = 1; return; end
            if (!busy) busy_ok = 0;
            @(negedge clk);
        end
    endtask

    task automatic do_rst(input bit nmi, input int l);
        logic [31:0] base;
        logic [7:0]  r0;
        bit seen, bok;
        @(negedge clk);
        reset_pin = 0;
        nmi_lvl = nmi;
        lat = l;
        repeat (3) @(negedge clk);
        chk(busy == 1 && mem_req == 0 && pc_we == 0 && mask_we == 0, "R3 held in reset",
            {29'd0, busy, mem_req, pc_we}, 32'h4);
        r0 = n_rd;
        base = nmi ? 32'h0 : 32'h8;
        reset_pin = 1;
        @(negedge clk);
        nmi_lvl = ~nmi;
        wait_commit(seen, bok);
        chk(seen, "R1 reset commit seen", {31'd0, seen}, 1);
        chk(bok, "R11 busy during reset entry", {31'd0, bok}, 1);
        chk(n_rd - r0 == 8'd2, "R1 reset read count", {24'd0, n_rd - r0}, 2);
        chk(r_addr[r0] == base, "R1 reset PC address", r_addr[r0], base);
        chk(r_addr[r0 + 8'd1] == base + 4, "R1 reset SP address", r_addr[r0 + 8'd1], base + 4);
        chk(pc_val == memf(base), "R2 reset PC", pc_val, memf(base));
        chk(sp_val == memf(base + 4), "R2 reset SP", sp_val, memf(base + 4));
        chk(sp_we && vbr_we && mask_we, "R2 reset strobes", {29'd0, sp_we, vbr_we, mask_we}, 7);
        chk(vbr_val == 0, "R2 reset VBR", vbr_val, 0);
        chk(mask_val == 4'hF, "R2 reset mask", {28'd0, mask_val}, 32'hF);
        chk(busy == 0, "R11 busy low at commit", {31'd0, busy}, 0);
        @(negedge clk);
        chk(!pc_we && !sp_we && !vbr_we && !mask_we, "R12 strobe single cycle",
            {28'd0, pc_we, sp_we, vbr_we, mask_we}, 0);
    endtask

    // kind: 0 addr err, 1 irq, 2 slot, 3 illeg, 4 trap; multi adds lower-priority causes
    task automatic run_exc(input int kind, input bit multi, input logic [3:0] lv,
                           input logic [7:0] v, input logic [31:0] sp, input logic [31:0] vbr,
                           input int l, input string tag);
        logic [31:0] sr, pc, va;
        logic [7:0]  w0, r0;
        logic [7:0]  ev;
        bit seen, bok;
        sr = 32'h0000_00F0 ^ {24'd0, v};
        pc = 32'h0400_1000 + {24'd0, v};
        lat = l;
        w0 = n_wr;
        r0 = n_rd;
        @(negedge clk);
        sr_in = sr; pc_in = pc; sp_in = sp; vbr_in = vbr;
        irq_lvl = lv; irq_vec = v; trap_imm = v;
        insn_done = 1;
        case (kind)
            0: begin addr_err = 1; if (multi) begin irq_req = 1; trap_dec = 1; end end
            1: begin irq_req = 1; if (multi) begin slot_illeg_dec = 1; trap_dec = 1; end end
            2: begin slot_illeg_dec = 1; if (multi) begin illeg_dec = 1; trap_dec = 1; end end
            3: begin illeg_dec = 1; if (multi) trap_dec = 1; end
            default: trap_dec = 1;
        endcase
        case (kind)
            0: ev = 8'd9;
            2: ev = 8'd6;
            3: ev = 8'd4;
            default: ev = v;
        endcase
        va = vbr + {22'd0, ev, 2'b00};
        @(negedge clk);
        clear_req();
        sp_in = ~sp; pc_in = ~pc; sr_in = ~sr; vbr_in = ~vbr;
        chk(busy == 1, {tag, " R11 busy after accept"}, {31'd0, busy}, 1);
        wait_commit(seen, bok);
        chk(seen, {tag, " R10 commit seen"}, {31'd0, seen}, 1);
        chk(bok, {tag, " R11 busy held"}, {31'd0, bok}, 1);
        chk(n_wr - w0 == 8'd2, {tag, " R4 write count"}, {24'd0, n_wr - w0}, 2);
        chk(w_addr[w0] == sp - 4 && w_data[w0] == sr, {tag, " R4 SR push"}, w_addr[w0], sp - 4);
        chk(w_addr[w0 + 8'd1] == sp - 8 && w_data[w0 + 8'd1] == pc, {tag, " R4 PC push"},
            w_data[w0 + 8'd1], pc);
        chk(n_rd - r0 == 8'd1 && r_addr[r0] == va, {tag, " R5 R6 R9 vector address"}, r_addr[r0], va);
        chk(pc_val == memf(va), {tag, " R5 handler PC"}, pc_val, memf(va));
        chk(sp_val == sp - 8 && sp_we && !vbr_we, {tag, " R5 new SP"}, sp_val, sp - 8);
        if (kind == 1)
            chk(mask_we && mask_val == lv, {tag, " R7 mask level"}, {27'd0, mask_we, mask_val},
                {27'd1, lv});
        else
            chk(!mask_we, {tag, " R7 mask untouched"}, {31'd0, mask_we}, 0);
        chk(busy == 0, {tag, " R11 busy low at commit"}, {31'd0, busy}, 0);
        @(negedge clk);
        chk(!pc_we && !sp_we && !mask_we, {tag, " R12 strobe single cycle"},
            {29'd0, pc_we, sp_we, mask_we}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        reset_pin = 0; nmi_lvl = 1; insn_done = 1;
        irq_lvl = 0; irq_vec = 0; trap_imm = 0;
        sr_in = 0; pc_in = 0; sp_in = 0; vbr_in = 0;
        clear_req();
        repeat (2) @(negedge clk);
        chk(busy == 1 && pc_we == 0 && mem_req == 0, "R3 reset state",
            {30'd0, busy, mem_req}, 32'h2);

        // R1 R2: both reset flavours under each bus latency
        for (int l = 0; l < 3; l++) begin
            do_rst(1'b1, l);
            do_rst(1'b0, l);
        end

        // R6 R7: every interrupt level
        for (int i = 0; i < 16; i++)
            run_exc(1, 0, 4'(i), 8'(8'h40 + i), 32'h0000_8000 + 32'(i * 64),
                    32'h0010_0000 + 32'(i * 4096), i % 3, "irq sweep");

        // R6: trap vectors across the immediate range
        for (int i = 0; i < 16; i++)
            run_exc(4, 0, 4'(i), 8'(i * 17), 32'h0002_0000 - 32'(i * 4), 32'h0000_4000,
                    (i + 1) % 3, "trap sweep");

        // R6: fixed-vector causes, including stack wrap-around
        run_exc(0, 0, 4'h3, 8'h77, 32'h0000_0000, 32'h0000_1000, 0, "addr err");
        run_exc(2, 0, 4'h3, 8'h77, 32'h0000_0004, 32'hFFFF_FF00, 2, "slot illegal");
        run_exc(3, 0, 4'h3, 8'h77, 32'h1000_0000, 32'h0, 1, "general illegal");

        // R9: simultaneous causes
        run_exc(0, 1, 4'h5, 8'h21, 32'h0000_9000, 32'h0000_2000, 0, "R9 addr over irq/trap");
        run_exc(1, 1, 4'h6, 8'h22, 32'h0000_9000, 32'h0000_2000, 1, "R9 irq over slot/trap");
        run_exc(2, 1, 4'h7, 8'h23, 32'h0000_9000, 32'h0000_2000, 0, "R9 slot over illeg/trap");
        run_exc(3, 1, 4'h8, 8'h24, 32'h0000_9000, 32'h0000_2000, 2, "R9 illeg over trap");

        // R8: interrupt and address error wait for the instruction boundary
        @(negedge clk);
        insn_done = 0;
        irq_req = 1;
        addr_err = 1;
        repeat (4) @(negedge clk);
        chk(busy == 0 && mem_req == 0, "R8 held off before boundary",
            {30'd0, busy, mem_req}, 0);
        clear_req();
        trap_dec = 1;
        trap_imm = 8'h12;
        vbr_in = 32'h0000_3000;
        sp_in = 32'h0000_7000;
        @(negedge clk);
        trap_dec = 0;
        chk(busy == 1, "R8 trap taken without boundary", {31'd0, busy}, 1);
        begin
            bit seen, bok;
            wait_commit(seen, bok);
            chk(seen && pc_val == memf(32'h0000_3000 + 32'h48), "R8 trap handler",
                pc_val, memf(32'h0000_3048));
        end
        insn_done = 1;

        // R3: reset during an entry aborts it and runs a reset entry
        @(negedge clk);
        lat = 3;
        irq_req = 1; irq_vec = 8'h30; irq_lvl = 4'h9;
        sp_in = 32'h0000_5000; vbr_in = 32'h0;
        @(negedge clk);
        clear_req();
        @(negedge clk);
        do_rst(1'b0, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule